// File: doc/BRIEF.md
# Protected-Mode Data Segment Load Checker

This block decides whether a selector may be loaded into a data segment register or into the stack segment register while the processor runs in protected mode. On a start pulse it takes the selector, the current privilege level and a flag that says whether the target is the stack register. It locates the 8-byte descriptor in either the global or the local descriptor table and reads it over a simple 32-bit request/acknowledge memory port. It then applies the type, privilege and presence rules for that target.

The result is a one-cycle `done` pulse. With it comes either a fault with its vector and error code, or the decoded base, limit and attribute word for the segment cache. When a load succeeds and the descriptor's accessed bit is clear, the block sets that bit in memory before it reports. A null selector loaded into a data register skips the table entirely and yields an all-zero cache entry. The stack register has stricter rules than the data registers: it must be writable data whose requested privilege and descriptor privilege both equal the current privilege.

Top module: `seg_load_check`

## Requirements
- R1: A selector whose bits 15:2 are all zero, loaded with `is_stack`=0, completes without a fault and without any memory access, and reports base, limit and attribute all zero.
- R2: A selector whose bits 15:2 are all zero, loaded with `is_stack`=1, faults with vector 13 and error code 0 and makes no memory access.
- R3: Selector bit 2 picks the table (1 = local, 0 = global). The byte offset is the selector with bits 2:0 cleared. If offset+7 exceeds the chosen table's limit, the block faults with vector 13 and makes no memory access.
- R4: After a read, a descriptor whose S bit (high dword bit 12) is clear faults with vector 13.
- R5: For the stack register, the load faults with vector 13 in any of these cases: the code bit (high bit 11) is set, the writable bit (high bit 9) is clear, RPL (selector bits 1:0) differs from `cpl`, or DPL (high bits 14:13) differs from `cpl`.
- R6: For a data register, the load faults with vector 13 if the code bit is set and the readable bit (high bit 9) is clear. Unless the descriptor is conforming code (high bits 11 and 10 both set), it also faults when DPL < `cpl` or DPL < RPL.
- R7: The present bit (high bit 15) is checked only after R4 to R6 pass. When it is clear, the stack register faults with vector 12 and a data register faults with vector 11.
- R8: Every fault except R2 carries the error code `selector & 16'hFFFC`.
- R9: On a successful non-null load whose accessed bit (high bit 8) is clear, the block writes the high dword with bit 8 set to table base + offset + 4. It makes no write when the bit is already set, and no write on any fault.
- R10: On success the base is {low[31:16]... assembled as high[31:24], high[7:0], low[31:16]} from most to least significant byte. The limit is {high[19:16], low[15:0]}, and when the granularity bit (high bit 23) is set it becomes (limit<<12)|12'hFFF. The attribute output is the high dword with bit 8 set.
- R11: The block reads the low dword at table base + offset and then the high dword at offset + 4. It holds `mem_req` and the address steady until `mem_ack`.
- R12: `done` is a single-cycle pulse. `start` is ignored while an operation is in flight. The result outputs hold their values until the next operation ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check |
| is_stack | input | 1 | 1 = stack register target, 0 = data register |
| selector | input | 16 | Selector being loaded |
| cpl | input | 2 | Current privilege level |
| gdt_base | input | ADDR_W | Global table base address |
| gdt_limit | input | LIM_W | Global table limit in bytes |
| ldt_base | input | ADDR_W | Local table base address |
| ldt_limit | input | LIM_W | Local table limit in bytes |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Load rejected |
| vector | output | 8 | Fault vector (11, 12 or 13) |
| err_code | output | 16 | Fault error code |
| seg_base | output | 32 | Decoded segment base |
| seg_limit | output | 32 | Decoded, expanded segment limit |
| seg_attr | output | 32 | Descriptor high dword, accessed bit set |

## Verification
The assertions assume a memory that acknowledges a request only while `mem_req` is high, with a single-cycle `mem_ack` pulse. They also assume that `start` arrives only while the block is idle, or else is dropped. The bench memory model acknowledges one cycle after it sees a request and never acknowledges twice in a row. Its stimulus pulses `start` only after the previous `done`. Random descriptors are biased toward the segment and present bits so that the privilege and type paths are exercised often. Random table indices run a little past each table's limit.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_LOCATE, ST_RD_LO, ST_RD_HI, ST_JUDGE, ST_WR_HI, ST_DONE
   } seg_state_t;

   localparam logic [7:0] VEC_NOT_PRESENT = 8'd11;
   localparam logic [7:0] VEC_STACK       = 8'd12;
   localparam logic [7:0] VEC_GEN_PROT    = 8'd13;

   localparam int HB_ACCESSED = 8;
   localparam int HB_RW       = 9;
   localparam int HB_CONFORM  = 10;
   localparam int HB_CODE     = 11;
   localparam int HB_SEGMENT  = 12;
   localparam int HB_DPL_LO   = 13;
   localparam int HB_PRESENT  = 15;
   localparam int HB_GRAN     = 23;
endpackage

// File: rtl/seg_table_locate.sv
module seg_table_locate #(
   parameter int ADDR_W = 32,
   parameter int LIM_W  = 16
) (
   input  logic [15:0]       sel,
   input  logic [ADDR_W-1:0] gbase,
   input  logic [LIM_W-1:0]  glimit,
   input  logic [ADDR_W-1:0] lbase,
   input  logic [LIM_W-1:0]  llimit,
   output logic [ADDR_W-1:0] entry_addr,
   output logic              beyond,
   output logic              null_sel
);
   localparam int CMP_W = ((LIM_W > 16) ? LIM_W : 16) + 1;

   logic [15:0]      offset;
   logic [CMP_W-1:0] last_byte;
   logic [CMP_W-1:0] lim_ext;

   assign offset    = {sel[15:3], 3'b000};
   assign null_sel  = (sel[15:2] == 14'd0);
   assign last_byte = CMP_W'(offset) + CMP_W'(7);
   assign lim_ext   = sel[2] ? CMP_W'(llimit) : CMP_W'(glimit);
   assign beyond    = last_byte > lim_ext;

   generate
      if (ADDR_W > 16) begin : g_wide
         assign entry_addr = (sel[2] ? lbase : gbase) + {{(ADDR_W-16){1'b0}}, offset};
      end else begin : g_narrow
         assign entry_addr = (sel[2] ? lbase : gbase) + offset[ADDR_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/seg_rights_check.sv
module seg_rights_check
   import seg_load_pkg::*;
(
   input  logic [31:0] hi,
   input  logic [1:0]  rpl,
   input  logic [1:0]  cpl,
   input  logic        stack,
   output logic        violation,
   output logic        present
);
   logic [1:0] dpl;
   logic       is_code, rw, conform, seg;
   logic       stack_bad, data_bad;

   assign dpl     = hi[HB_DPL_LO +: 2];
   assign is_code = hi[HB_CODE];
   assign rw      = hi[HB_RW];
   assign conform = hi[HB_CONFORM];
   assign seg     = hi[HB_SEGMENT];
   assign present = hi[HB_PRESENT];

   always_comb begin
      stack_bad = is_code || !rw || (rpl != cpl) || (dpl != cpl);
      data_bad  = (is_code && !rw) ||
                  (!(is_code && conform) && ((dpl < cpl) || (dpl < rpl)));
      violation = !seg || (stack ? stack_bad : data_bad);
   end
endmodule

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
   import seg_load_pkg::*;
(
   input  logic [31:0] lo,
   input  logic [31:0] hi,
   output logic [31:0] base,
   output logic [31:0] limit,
   output logic [31:0] attr
);
   logic [19:0] raw_lim;

   assign base    = {hi[31:24], hi[7:0], lo[31:16]};
   assign raw_lim = {hi[19:16], lo[15:0]};
   assign limit   = hi[HB_GRAN] ? {raw_lim, 12'hFFF} : {12'd0, raw_lim};
   assign attr    = hi | (32'd1 << HB_ACCESSED);
endmodule

// File: rtl/seg_load_check.sv
module seg_load_check
   import seg_load_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int LIM_W        = 16,
   parameter bit SET_ACCESSED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_stack,
   input  logic [15:0]       selector,
   input  logic [1:0]        cpl,
   input  logic [ADDR_W-1:0] gdt_base,
   input  logic [LIM_W-1:0]  gdt_limit,
   input  logic [ADDR_W-1:0] ldt_base,
   input  logic [LIM_W-1:0]  ldt_limit,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack,
   output logic              done,
   output logic              fault,
   output logic [7:0]        vector,
   output logic [15:0]       err_code,
   output logic [31:0]       seg_base,
   output logic [31:0]       seg_limit,
   output logic [31:0]       seg_attr
);
   initial begin
      assert (ADDR_W >= 8 && ADDR_W <= 64)
         else $error("ADDR_W out of range");
      assert (LIM_W >= 3 && LIM_W <= 32)
         else $error("LIM_W out of range");
   end

   localparam logic [ADDR_W-1:0] HI_OFS = ADDR_W'(4);

   seg_state_t        state;
   logic [15:0]       sel_q;
   logic              stk_q;
   logic [1:0]        cpl_q;
   logic [31:0]       lo_q, hi_q;
   logic [ADDR_W-1:0] entry_addr;
   logic              beyond, null_sel;
   logic              violation, present;
   logic [31:0]       dec_base, dec_limit, dec_attr;
   logic              need_wb;
   logic [15:0]       sel_err;

   seg_table_locate #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_locate (
      .sel(sel_q), .gbase(gdt_base), .glimit(gdt_limit),
      .lbase(ldt_base), .llimit(ldt_limit),
      .entry_addr(entry_addr), .beyond(beyond), .null_sel(null_sel)
   );

   seg_rights_check u_rights (
      .hi(hi_q), .rpl(sel_q[1:0]), .cpl(cpl_q), .stack(stk_q),
      .violation(violation), .present(present)
   );

   seg_desc_decode u_decode (
      .lo(lo_q), .hi(hi_q),
      .base(dec_base), .limit(dec_limit), .attr(dec_attr)
   );

   generate
      if (SET_ACCESSED) begin : g_wb
         assign need_wb = !hi_q[HB_ACCESSED];
      end else begin : g_no_wb
         assign need_wb = 1'b0;
      end
   endgenerate

   assign sel_err = sel_q & 16'hFFFC;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         sel_q     <= '0;
         stk_q     <= 1'b0;
         cpl_q     <= '0;
         lo_q      <= '0;
         hi_q      <= '0;
         fault     <= 1'b0;
         vector    <= '0;
         err_code  <= '0;
         seg_base  <= '0;
         seg_limit <= '0;
         seg_attr  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  sel_q <= selector;
                  stk_q <= is_stack;
                  cpl_q <= cpl;
                  state <= ST_LOCATE;
               end
            end
            ST_LOCATE: begin
               if (null_sel) begin
                  fault     <= stk_q;
                  vector    <= stk_q ? VEC_GEN_PROT : 8'd0;
                  err_code  <= 16'd0;
                  seg_base  <= '0;
                  seg_limit <= '0;
                  seg_attr  <= '0;
                  state     <= ST_DONE;
               end else if (beyond) begin
                  fault    <= 1'b1;
                  vector   <= VEC_GEN_PROT;
                  err_code <= sel_err;
                  state    <= ST_DONE;
               end else begin
                  state <= ST_RD_LO;
               end
            end
            ST_RD_LO: begin
               if (mem_ack) begin
                  lo_q  <= mem_rdata;
                  state <= ST_RD_HI;
               end
            end
            ST_RD_HI: begin
               if (mem_ack) begin
                  hi_q  <= mem_rdata;
                  state <= ST_JUDGE;
               end
            end
            ST_JUDGE: begin
               if (violation) begin
                  fault    <= 1'b1;
                  vector   <= VEC_GEN_PROT;
                  err_code <= sel_err;
                  state    <= ST_DONE;
               end else if (!present) begin
                  fault    <= 1'b1;
                  vector   <= stk_q ? VEC_STACK : VEC_NOT_PRESENT;
                  err_code <= sel_err;
                  state    <= ST_DONE;
               end else begin
                  fault     <= 1'b0;
                  vector    <= 8'd0;
                  err_code  <= 16'd0;
                  seg_base  <= dec_base;
                  seg_limit <= dec_limit;
                  seg_attr  <= dec_attr;
                  state     <= need_wb ? ST_WR_HI : ST_DONE;
               end
            end
            ST_WR_HI: begin
               if (mem_ack) state <= ST_DONE;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = (state == ST_RD_LO) || (state == ST_RD_HI) || (state == ST_WR_HI);
      mem_we    = (state == ST_WR_HI);
      mem_addr  = (state == ST_RD_LO) ? entry_addr : entry_addr + HI_OFS;
      mem_wdata = hi_q | (32'd1 << HB_ACCESSED);
      done      = (state == ST_DONE);
   end
endmodule

// File: rtl/seg_load_check_sva.sv
module seg_load_check_sva #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              is_stack,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [31:0]       mem_wdata,
   input logic              mem_ack,
   input logic              done,
   input logic              fault,
   input logic [7:0]        vector,
   input logic [15:0]       err_code,
   input logic [31:0]       seg_attr
);
   logic busy, stk_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         stk_seen <= 1'b0;
      end else if (!busy && start) begin
         busy     <= 1'b1;
         stk_seen <= is_stack;
      end else if (done) begin
         busy <= 1'b0;
      end
   end

   a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r12_no_idle_activity: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req && !done);

   a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   a_r9_wb_sets_accessed: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_wdata[8]);

   a_r8_err_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      done && fault |-> err_code[1:0] == 2'b00);

   a_r7_vector_legal: assert property (@(posedge clk) disable iff (!rst_n)
      done && fault |-> (vector == 8'd11 && !stk_seen) ||
                        (vector == 8'd12 && stk_seen) || vector == 8'd13);

   a_r10_attr_accessed: assert property (@(posedge clk) disable iff (!rst_n)
      done && !fault && seg_attr != 32'd0 |-> seg_attr[8]);
endmodule

bind seg_load_check seg_load_check_sva #(.ADDR_W(ADDR_W)) u_sva (
   .clk(clk), .rst_n(rst_n), .start(start), .is_stack(is_stack),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .mem_ack(mem_ack), .done(done), .fault(fault),
   .vector(vector), .err_code(err_code), .seg_attr(seg_attr)
);

// File: tb/test_seg_load_check.sv
module test_seg_load_check;
   localparam int ADDR_W = 32;
   localparam int LIM_W  = 16;
   localparam logic [31:0] GBASE = 32'h000;
   localparam logic [15:0] GLIM  = 16'h007F;
   localparam logic [31:0] LBASE = 32'h400;
   localparam logic [15:0] LLIM  = 16'h003F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, is_stack = 1'b0;
   logic [15:0] selector = '0;
   logic [1:0]  cpl = '0;
   logic mem_req, mem_we, mem_ack;
   logic [ADDR_W-1:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic done, fault;
   logic [7:0] vector;
   logic [15:0] err_code;
   logic [31:0] seg_base, seg_limit, seg_attr;

   int n_cmp = 0, n_bad = 0;
   int rd_cnt = 0, wr_cnt = 0;
   logic [31:0] wr_addr_seen, wr_data_seen;
   logic [31:0] mem [0:511];
   logic        host_we = 1'b0;
   logic [8:0]  host_idx = '0;
   logic [31:0] host_data = '0;

   always #5 clk = ~clk;

   seg_load_check #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) i_seg_load_check (
      .clk(clk), .rst_n(rst_n), .start(start), .is_stack(is_stack),
      .selector(selector), .cpl(cpl),
      .gdt_base(GBASE), .gdt_limit(GLIM), .ldt_base(LBASE), .ldt_limit(LLIM),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .done(done), .fault(fault), .vector(vector), .err_code(err_code),
      .seg_base(seg_base), .seg_limit(seg_limit), .seg_attr(seg_attr)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
      end else begin
         mem_ack <= mem_req && !mem_ack;
         if (host_we) mem[host_idx] <= host_data;
         else if (mem_req && !mem_ack) begin
            if (mem_we) begin
               mem[mem_addr[10:2]] <= mem_wdata;
               wr_cnt       <= wr_cnt + 1;
               wr_addr_seen <= mem_addr;
               wr_data_seen <= mem_wdata;
            end else begin
               mem_rdata <= mem[mem_addr[10:2]];
               rd_cnt    <= rd_cnt + 1;
            end
         end
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic put_word(logic [31:0] addr, logic [31:0] data);
      @(negedge clk);
      host_we = 1'b1; host_idx = addr[10:2]; host_data = data;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic model(input logic [15:0] sel, input logic stk, input logic [1:0] c,
                        input logic [31:0] lo, input logic [31:0] hi,
                        output logic f, output logic [7:0] v, output logic [15:0] e,
                        output logic [31:0] b, output logic [31:0] l,
                        output logic [31:0] a, output logic wb, output logic rd);
      logic [1:0] rpl, dpl;
      logic bad;
      logic [19:0] rl;
      int last;
      rpl = sel[1:0]; dpl = hi[14:13];
      f = 0; v = 0; e = 0; b = 0; l = 0; a = 0; wb = 0; rd = 0;
      last = int'({sel[15:3], 3'b000}) + 7;
      if (sel[15:2] == 0) begin
         f = stk; v = stk ? 8'd13 : 8'd0;
         return;
      end
      if (last > int'(sel[2] ? LLIM : GLIM)) begin
         f = 1; v = 13; e = sel & 16'hFFFC;
         return;
      end
      rd = 1;
      if (stk) bad = hi[11] || !hi[9] || rpl != c || dpl != c;
      else     bad = (hi[11] && !hi[9]) || (!(hi[11] && hi[10]) && (dpl < c || dpl < rpl));
      bad = bad || !hi[12];
      if (bad) begin f = 1; v = 13; e = sel & 16'hFFFC; return; end
      if (!hi[15]) begin f = 1; v = stk ? 8'd12 : 8'd11; e = sel & 16'hFFFC; return; end
      b  = {hi[31:24], hi[7:0], lo[31:16]};
      rl = {hi[19:16], lo[15:0]};
      l  = hi[23] ? {rl, 12'hFFF} : {12'd0, rl};
      a  = hi | 32'h100;
      wb = !hi[8];
   endtask

   task automatic run_op(logic [15:0] sel, logic stk, logic [1:0] c,
                         logic [31:0] lo, logic [31:0] hi);
      logic ef, ewb, erd;
      logic [7:0] ev;
      logic [15:0] ee;
      logic [31:0] eb, el, ea, ent;
      int guard;
      ent = (sel[2] ? LBASE : GBASE) + {16'd0, sel[15:3], 3'b000};
      put_word(ent, lo);
      put_word(ent + 4, hi);
      model(sel, stk, c, lo, hi, ef, ev, ee, eb, el, ea, ewb, erd);
      @(negedge clk);
      rd_cnt = 0; wr_cnt = 0;
      start = 1; selector = sel; is_stack = stk; cpl = c;
      @(negedge clk);
      start = 0;
      selector = ~sel;
      guard = 0;
      while (!done && guard < 100) begin @(negedge clk); guard++; end
      if (!done) begin
         check("R12 done timeout", 0, 1);
         return;
      end
      check("R12 fault", {31'd0, fault}, {31'd0, ef});
      if (ef) begin
         check("R7 vector", {24'd0, vector}, {24'd0, ev});
         check("R8 err_code", {16'd0, err_code}, {16'd0, ee});
      end else begin
         check("R10 base", seg_base, eb);
         check("R10 limit", seg_limit, el);
         check("R10 attr", seg_attr, ea);
      end
      check("R11 reads", rd_cnt, erd ? 2 : 0);
      check("R9 writes", wr_cnt, ewb ? 1 : 0);
      if (ewb) begin
         check("R9 wb addr", wr_addr_seen, ent + 4);
         check("R9 wb data", wr_data_seen, hi | 32'h100);
      end
      @(negedge clk);
      check("R12 pulse", {31'd0, done}, 32'd0);
   endtask

   // directed descriptor high words: P=1 S=1 DPL=0 data writable
   localparam logic [31:0] HI_DATA = 32'h00409200;

   initial begin
      static int seed = 32'h5EC7;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check("R12 reset done", {31'd0, done}, 32'd0);
      check("R11 reset req", {31'd0, mem_req}, 32'd0);
      rst_n = 1;
      @(negedge clk);

      run_op(16'h0000, 0, 0, 32'h1234, HI_DATA);               // R1
      run_op(16'h0003, 1, 0, 32'h1234, HI_DATA);               // R2
      run_op(16'h0003, 0, 3, 32'h1234, HI_DATA);               // R1 with rpl
      run_op(16'h0078, 0, 0, 32'hABCD1111, 32'h12C09234);      // R3 last fit, R10 gran
      run_op(16'h0080, 0, 0, 32'h0, HI_DATA);                  // R3 past limit
      run_op(16'h003C, 0, 0, 32'h5555FFFF, HI_DATA);           // R3 local, fits
      run_op(16'h0044, 0, 0, 32'h0, HI_DATA);                  // R3 local beyond
      run_op(16'h0010, 0, 0, 32'h0, 32'h00408200);             // R4 system
      run_op(16'h0010, 1, 0, 32'h0, 32'h00409A00);             // R5 code
      run_op(16'h0010, 1, 0, 32'h0, 32'h00409000);             // R5 not writable
      run_op(16'h0011, 1, 0, 32'h0, HI_DATA);                  // R5 rpl mismatch
      run_op(16'h0010, 0, 0, 32'h0, 32'h00409800);             // R6 execute-only
      run_op(16'h0010, 0, 3, 32'h0, 32'h00409E00);             // R6 conforming ok
      run_op(16'h0010, 0, 3, 32'h0, 32'h00409A00);             // R6 dpl<cpl
      run_op(16'h0013, 0, 2, 32'h0, 32'h0040D200);             // R6 dpl<rpl
      run_op(16'h0010, 1, 0, 32'h0, 32'h00401200);             // R7 stack NP
      run_op(16'h0010, 0, 0, 32'h0, 32'h00401200);             // R7 data NP
      run_op(16'h0010, 0, 0, 32'h0, 32'h00409300);             // R9 already accessed
      run_op(16'h0010, 0, 3, 32'h0, 32'h00401000);             // R7 priv before present

      for (int i = 0; i < 300; i++) begin
         logic [15:0] s;
         logic [31:0] lo, hi;
         s  = {$urandom_range(0, 20), $urandom_range(0, 1), $urandom_range(0, 3)};
         s[15:3] = 13'($urandom_range(0, 20));
         lo = $urandom;
         hi = $urandom;
         if ($urandom_range(0, 9) != 0) hi[12] = 1;
         if ($urandom_range(0, 7) != 0) hi[15] = 1;
         run_op(s, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), lo, hi);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R12 watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule